// File: doc/BRIEF.md
# ADC Bring-up Sequencer

This block takes a multi-channel biopotential ADC from power-on to a configured, idle state before any sample capture begins. After system reset it either pulses the converter's active-high reset pin or, when the board has no such pin, sends the device's software reset opcode. It then waits out the device's internal restart time, counted exactly in device clock periods, and stops the continuous-read mode the converter starts in, so that register access works.

Next it reads the identification register, checks that the family code is one of the two accepted ones, and derives the channel count and the variant flag from the register's fields at run time. On success it writes the test-signal configuration register and the reference configuration register, the latter shaped by two board-level inputs (internal reference in use, analog supply high enough for the 4 V reference). Every transfer goes through an external command engine over a request/acknowledge port. Once the last write is acknowledged, the block raises `ready` and the rest of the chip may start capture. An unknown identification code stops the sequence with a latched `error`.

Top module: `adc_bringup_seq`

## Requirements
- R1: With `pin_present` high, `adc_reset` is high throughout system reset and falls on the `DCLK_DIV*RST_DCLK`-th rising clock edge after `rst_n` rises. With `pin_present` low, `adc_reset` stays low.
- R2: With `pin_present` low, the first request is the plain opcode 0x06 (`cmd_reg` low).
- R3: After reset ends (the fall of `adc_reset`, or the acknowledge of opcode 0x06), no request is made for exactly `DCLK_DIV*SETTLE_DCLK` clock cycles. The next request is the plain opcode 0x11, which stops continuous read and comes before any register access.
- R4: The identification read is opcode 0x20 (register 0 read), `cmd_reg` high, `cmd_arg` 0x00. `cmd_rdata` is taken in the cycle `cmd_ack` is high.
- R5: Identification bits [7:3] equal to 5'b10010 select the base family (`variant_r`=0), and 5'b11010 selects the R family (`variant_r`=1). Any other code raises `error` and issues no further requests.
- R6: `chan_count` is 0 until an accepted identification, then equals 4 + 2*ID[2:0].
- R7: After an accepted identification, opcode 0x42 (register 2 write) is requested with `cmd_reg` high and data 0x55 (bits 6, 4, 2, 0).
- R8: Opcode 0x43 (register 3 write) follows with data that always has bit 6 set. Bit 7 is set when `int_ref` is high, and bit 5 is set when both `int_ref` and `supply_hi` are high.
- R9: While `cmd_req` is high and `cmd_ack` low, the request and its `cmd_byte`/`cmd_arg` hold steady into the next cycle.
- R10: `ready` rises after the acknowledge of the 0x43 write. From then on no request is made, and `ready` stays high until reset.
- R11: `error` and `ready` are never high together, and `error` stays high until the next system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| pin_present | input | 1 | Board has a hardware reset line to the ADC |
| int_ref | input | 1 | Internal voltage reference is used |
| supply_hi | input | 1 | Analog supply is at least 4.4 V |
| adc_reset | output | 1 | Active-high reset line to the ADC |
| cmd_req | output | 1 | Command request to the engine |
| cmd_reg | output | 1 | Request is a single-register transfer (count byte zero) |
| cmd_byte | output | 8 | Opcode byte |
| cmd_arg | output | 8 | Write data (0 for reads) |
| cmd_ack | input | 1 | One-cycle acknowledge of the pending request |
| cmd_rdata | input | 8 | Register data returned with the acknowledge |
| ready | output | 1 | Bring-up finished |
| error | output | 1 | Unknown identification code (latched) |
| chan_count | output | CHAN_W | Decoded channel count |
| variant_r | output | 1 | R family detected |

## Verification
The main function is swept across all 256 identification codes, and the low three code bits also drive the three board inputs, so each accepted family is seen with every reset style and every reference setting. The sweep separates the two accepted family codes from their 30 rejected neighbours, checks the channel formula at every field value, and compares the pin-reset and opcode-reset paths, including the exact settle gap each one produces. The command log of each run is compared entry by entry with a list the bench builds. This catches a reordered, missing or extra transfer, and a wrong bit in the reference register.

// File: rtl/bup_pkg.sv
package bup_pkg;

   typedef enum logic [3:0] {
      ST_HOLD,
      ST_RSTCMD,
      ST_SETTLE,
      ST_HALT,
      ST_IDRD,
      ST_CFG2,
      ST_CFG3,
      ST_READY,
      ST_FAIL
   } bup_state_e;

   // opcodes decoded by the converter
   localparam logic [7:0] OP_SOFT_RESET = 8'h06;
   localparam logic [7:0] OP_STOP_RDC   = 8'h11;
   localparam logic [7:0] OP_REG_READ   = 8'h20;
   localparam logic [7:0] OP_REG_WRITE  = 8'h40;

   // register addresses inside the converter
   localparam logic [4:0] ADR_IDENT = 5'd0;
   localparam logic [4:0] ADR_TSIG  = 5'd2;
   localparam logic [4:0] ADR_REFC  = 5'd3;

   // accepted family codes (ID bits 7:3), R family in the upper slot
   localparam int          FAM_N     = 2;
   localparam logic [9:0]  FAM_LIST  = {5'b11010, 5'b10010};
   localparam int          FAM_R_IDX = 1;

   typedef struct packed {
      logic       req;
      logic       is_reg;
      logic [7:0] op;
      logic [7:0] arg;
   } bup_cmd_t;

endpackage

// File: rtl/bup_timer.sv
module bup_timer #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic [W-1:0] last,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("bup_timer: W must be at least 1");
      end
   endgenerate

   assign expired = (cnt_q == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bup_id_decode.sv
module bup_id_decode #(
   parameter int                CHAN_W = 5,
   parameter int                NFAM   = 2,
   parameter logic [NFAM*5-1:0] CODES  = {5'b11010, 5'b10010},
   parameter int                R_IDX  = 1
) (
   input  logic [7:0]        id,
   output logic              known,
   output logic              variant,
   output logic [CHAN_W-1:0] chans
);

   logic [NFAM-1:0] hit;

   generate
      if (CHAN_W < 5) begin : g_bad_cw
         $error("bup_id_decode: CHAN_W too narrow for 18 channels");
      end
      if (R_IDX >= NFAM) begin : g_bad_ridx
         $error("bup_id_decode: R_IDX out of range");
      end
      for (genvar i = 0; i < NFAM; i++) begin : g_fam
         assign hit[i] = (id[7:3] == CODES[i*5 +: 5]);
      end
   endgenerate

   assign known   = |hit;
   assign variant = hit[R_IDX];
   assign chans   = CHAN_W'(4) + CHAN_W'({id[2:0], 1'b0});

endmodule

// File: rtl/bup_cfg_pack.sv
module bup_cfg_pack (
   input  logic       int_ref,
   input  logic       supply_hi,
   output logic [7:0] tsig_val,
   output logic [7:0] refc_val
);

   // test signal: reserved bit, internal source, doubled amplitude, fast rate
   assign tsig_val = 8'b0101_0101;

   always_comb begin
      refc_val    = 8'b0100_0000;
      refc_val[7] = int_ref;
      refc_val[5] = int_ref & supply_hi;
   end

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
   import bup_pkg::*;
#(
   parameter int DCLK_DIV    = 4,
   parameter int RST_DCLK    = 2,
   parameter int SETTLE_DCLK = 18,
   parameter int CHAN_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_present,
   input  logic              int_ref,
   input  logic              supply_hi,
   output logic              adc_reset,
   output logic              cmd_req,
   output logic              cmd_reg,
   output logic [7:0]        cmd_byte,
   output logic [7:0]        cmd_arg,
   input  logic              cmd_ack,
   input  logic [7:0]        cmd_rdata,
   output logic              ready,
   output logic              error,
   output logic [CHAN_W-1:0] chan_count,
   output logic              variant_r
);

   localparam int HOLD_CYC   = DCLK_DIV * RST_DCLK;
   localparam int SETTLE_CYC = DCLK_DIV * SETTLE_DCLK;
   localparam int LONGEST    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
   localparam int TMR_W      = $clog2(LONGEST + 1);

   generate
      if (DCLK_DIV < 1) begin : g_bad_div
         $error("adc_bringup_seq: DCLK_DIV must be positive");
      end
      if (RST_DCLK < 2) begin : g_bad_rst
         $error("adc_bringup_seq: reset pulse must span two device clocks");
      end
      if (SETTLE_DCLK < 1) begin : g_bad_settle
         $error("adc_bringup_seq: SETTLE_DCLK must be positive");
      end
   endgenerate

   bup_state_e        state_q, state_d;
   logic              tmr_clear, tmr_done;
   logic [TMR_W-1:0]  tmr_last;
   logic              id_known, id_variant;
   logic [CHAN_W-1:0] id_chans;
   logic [7:0]        tsig_val, refc_val;
   logic [7:0]        refc_q;
   logic [CHAN_W-1:0] chan_q;
   logic              var_q;
   bup_cmd_t          cmd;
   logic              id_take;

   bup_timer #(.W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (tmr_clear),
      .last    (tmr_last),
      .expired (tmr_done)
   );

   bup_id_decode #(
      .CHAN_W (CHAN_W),
      .NFAM   (FAM_N),
      .CODES  (FAM_LIST),
      .R_IDX  (FAM_R_IDX)
   ) u_dec (
      .id      (cmd_rdata),
      .known   (id_known),
      .variant (id_variant),
      .chans   (id_chans)
   );

   bup_cfg_pack u_cfg (
      .int_ref   (int_ref),
      .supply_hi (supply_hi),
      .tsig_val  (tsig_val),
      .refc_val  (refc_val)
   );

   // wait length for the two timed states
   always_comb begin
      case (state_q)
         ST_HOLD:   tmr_last = TMR_W'(HOLD_CYC - 1);
         ST_SETTLE: tmr_last = TMR_W'(SETTLE_CYC - 1);
         default:   tmr_last = '0;
      endcase
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_HOLD:   if (tmr_done) state_d = pin_present ? ST_SETTLE : ST_RSTCMD;
         ST_RSTCMD: if (cmd_ack)  state_d = ST_SETTLE;
         ST_SETTLE: if (tmr_done) state_d = ST_HALT;
         ST_HALT:   if (cmd_ack)  state_d = ST_IDRD;
         ST_IDRD:   if (cmd_ack)  state_d = id_known ? ST_CFG2 : ST_FAIL;
         ST_CFG2:   if (cmd_ack)  state_d = ST_CFG3;
         ST_CFG3:   if (cmd_ack)  state_d = ST_READY;
         ST_READY:  state_d = ST_READY;
         ST_FAIL:   state_d = ST_FAIL;
         default:   state_d = ST_FAIL;
      endcase
   end

   assign tmr_clear = (state_d != state_q);
   assign id_take   = (state_q == ST_IDRD) && cmd_ack && id_known;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q <= '0;
         var_q  <= 1'b0;
         refc_q <= '0;
      end else if (id_take) begin
         chan_q <= id_chans;
         var_q  <= id_variant;
         refc_q <= refc_val;
      end
   end

   // command formation from the current step
   always_comb begin
      cmd = '0;
      case (state_q)
         ST_RSTCMD: begin
            cmd.req = 1'b1;
            cmd.op  = OP_SOFT_RESET;
         end
         ST_HALT: begin
            cmd.req = 1'b1;
            cmd.op  = OP_STOP_RDC;
         end
         ST_IDRD: begin
            cmd.req    = 1'b1;
            cmd.is_reg = 1'b1;
            cmd.op     = OP_REG_READ | {3'b000, ADR_IDENT};
         end
         ST_CFG2: begin
            cmd.req    = 1'b1;
            cmd.is_reg = 1'b1;
            cmd.op     = OP_REG_WRITE | {3'b000, ADR_TSIG};
            cmd.arg    = tsig_val;
         end
         ST_CFG3: begin
            cmd.req    = 1'b1;
            cmd.is_reg = 1'b1;
            cmd.op     = OP_REG_WRITE | {3'b000, ADR_REFC};
            cmd.arg    = refc_q;
         end
         default: cmd = '0;
      endcase
   end

   assign cmd_req    = cmd.req;
   assign cmd_reg    = cmd.is_reg;
   assign cmd_byte   = cmd.op;
   assign cmd_arg    = cmd.arg;
   assign adc_reset  = (state_q == ST_HOLD) && pin_present;
   assign ready      = (state_q == ST_READY);
   assign error      = (state_q == ST_FAIL);
   assign chan_count = chan_q;
   assign variant_r  = var_q;

endmodule

// File: rtl/bup_checker.sv
module bup_checker #(
   parameter int CHAN_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_reset,
   input logic              cmd_req,
   input logic [7:0]        cmd_byte,
   input logic [7:0]        cmd_arg,
   input logic              cmd_ack,
   input logic              ready,
   input logic              error,
   input logic [CHAN_W-1:0] chan_count
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_byte) && $stable(cmd_arg))); // R9

   AST_NO_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      adc_reset |-> !cmd_req); // R1

   AST_QUIET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_reset) |-> !cmd_req); // R3

   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> (ready && !cmd_req)); // R10

   AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> (error && !cmd_req)); // R11

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && error)); // R11

   AST_CHAN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!chan_count[0] && chan_count >= CHAN_W'(4))); // R6

endmodule

bind adc_bringup_seq bup_checker #(.CHAN_W(CHAN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .adc_reset  (adc_reset),
   .cmd_req    (cmd_req),
   .cmd_byte   (cmd_byte),
   .cmd_arg    (cmd_arg),
   .cmd_ack    (cmd_ack),
   .ready      (ready),
   .error      (error),
   .chan_count (chan_count)
);

// File: tb/sim_adc_bringup_seq.sv
module sim_adc_bringup_seq;

   localparam int DIV    = 4;
   localparam int RSTD   = 2;
   localparam int SETD   = 18;
   localparam int CW     = 5;
   localparam int HOLD   = DIV * RSTD;
   localparam int SETTLE = DIV * SETD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin_present = 1'b1;
   logic          int_ref = 1'b0;
   logic          supply_hi = 1'b0;
   logic          adc_reset;
   logic          cmd_req, cmd_reg;
   logic [7:0]    cmd_byte, cmd_arg;
   logic          cmd_ack = 1'b0;
   logic [7:0]    cmd_rdata = 8'h00;
   logic          ready, error, variant_r;
   logic [CW-1:0] chan_count;

   int checks = 0;
   int errors = 0;
   int total_cyc = 0;

   int log_op [8];
   int log_arg[8];
   int log_reg[8];

   always #2 clk = ~clk;

   adc_bringup_seq #(
      .DCLK_DIV(DIV), .RST_DCLK(RSTD), .SETTLE_DCLK(SETD), .CHAN_W(CW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pin_present(pin_present), .int_ref(int_ref),
      .supply_hi(supply_hi), .adc_reset(adc_reset), .cmd_req(cmd_req),
      .cmd_reg(cmd_reg), .cmd_byte(cmd_byte), .cmd_arg(cmd_arg),
      .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .ready(ready), .error(error),
      .chan_count(chan_count), .variant_r(variant_r)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_one(input logic [7:0] id, input logic pin, input logic iref, input logic shi);
      int   hi = 0, gap = 0, waitc = 0, nlog = 0, tail = -1;
      bit   armed = 0, gap_done = 0, prev_rst;
      logic [7:0] hb = 0, ha = 0;
      bit   ok;
      int   exp_op[5], exp_arg[5], exp_reg[5], exp_n, exp_cfg3;
      string tags[5];

      pin_present = pin; int_ref = iref; supply_hi = shi;
      rst_n = 1'b0; cmd_ack = 1'b0;
      repeat (3) @(negedge clk);
      // reset state, R1 pin level during reset
      chk(ready == 1'b0 && error == 1'b0, "R10 reset flags", {ready, error}, 0);
      chk(chan_count == '0 && cmd_req == 1'b0, "R6 reset count", chan_count, 0);
      chk(adc_reset == pin, "R1 level in reset", adc_reset, pin);
      rst_n = 1'b1;
      prev_rst = adc_reset;

      for (int cyc = 0; cyc < 600; cyc++) begin
         @(negedge clk);
         if (cmd_ack) begin
            cmd_ack = 1'b0;
            waitc = 0;
            if (nlog > 0 && log_op[nlog-1] == 8'h06 && !gap_done) armed = 1;
         end
         if (prev_rst && !adc_reset) armed = 1;
         prev_rst = adc_reset;
         if (adc_reset) hi++;
         if (armed) begin
            if (cmd_req) begin
               armed = 0;
               gap_done = 1;
            end else begin
               gap++;
            end
         end
         if (cmd_req) begin
            waitc++;
            if (waitc == 1) begin
               hb = cmd_byte;
               ha = cmd_arg;
            end else begin
               chk(cmd_byte == hb && cmd_arg == ha, "R9 request held", cmd_byte, hb);
               if (nlog < 8) begin
                  log_op[nlog]  = cmd_byte;
                  log_arg[nlog] = cmd_arg;
                  log_reg[nlog] = cmd_reg;
               end
               nlog++;
               cmd_rdata = (cmd_byte == 8'h20) ? id : 8'hA5;
               cmd_ack = 1'b1;
            end
         end
         if ((ready || error) && tail < 0) tail = 0;
         if (tail >= 0) tail++;
         if (tail > 20) break;
      end

      ok = (id[7:3] == 5'b10010) || (id[7:3] == 5'b11010);
      exp_cfg3 = 8'h40 | (iref ? 8'h80 : 0) | ((iref && shi) ? 8'h20 : 0);
      exp_n = 0;
      if (!pin) begin
         exp_op[exp_n] = 8'h06; exp_arg[exp_n] = 0; exp_reg[exp_n] = 0; tags[exp_n] = "R2 reset opcode"; exp_n++;
      end
      exp_op[exp_n] = 8'h11; exp_arg[exp_n] = 0; exp_reg[exp_n] = 0; tags[exp_n] = "R3 stop-read opcode"; exp_n++;
      exp_op[exp_n] = 8'h20; exp_arg[exp_n] = 0; exp_reg[exp_n] = 1; tags[exp_n] = "R4 id read"; exp_n++;
      if (ok) begin
         exp_op[exp_n] = 8'h42; exp_arg[exp_n] = 8'h55; exp_reg[exp_n] = 1; tags[exp_n] = "R7 test-signal write"; exp_n++;
         exp_op[exp_n] = 8'h43; exp_arg[exp_n] = exp_cfg3; exp_reg[exp_n] = 1; tags[exp_n] = "R8 reference write"; exp_n++;
      end

      chk(tail >= 0, "R10 sequence finished", tail, 0);
      chk(hi == (pin ? HOLD - 1 : 0), "R1 reset width", hi, pin ? HOLD - 1 : 0);
      chk(gap == SETTLE, "R3 settle gap", gap, SETTLE);
      chk(nlog == exp_n, "R10 request count", nlog, exp_n);
      for (int k = 0; k < exp_n && k < nlog; k++) begin
         chk(log_op[k] == exp_op[k] && log_arg[k] == exp_arg[k] && log_reg[k] == exp_reg[k],
             tags[k], {log_op[k][7:0], log_arg[k][7:0], log_reg[k][0]},
             {exp_op[k][7:0], exp_arg[k][7:0], exp_reg[k][0]});
      end
      chk(ready == ok, "R10 ready", ready, ok);
      chk(error == !ok, "R5 error on unknown id", error, !ok);
      chk(!(ready && error), "R11 flags exclusive", {ready, error}, 0);
      chk(variant_r == (ok && id[7:3] == 5'b11010), "R5 variant", variant_r, ok && id[7:3] == 5'b11010);
      chk(int'(chan_count) == (ok ? 4 + 2 * id[2:0] : 0), "R6 channel count", chan_count,
          ok ? 4 + 2 * id[2:0] : 0);
      repeat (10) @(negedge clk);
      chk(error == !ok && cmd_req == 1'b0, "R11 error sticky", {error, cmd_req}, !ok);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         total_cyc++;
         if (total_cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", total_cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      for (int v = 0; v < 256; v++) begin
         run_one(8'(v), v[0], v[1], v[2]);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule